// File: doc/BRIEF.md
# Way-Hinted Physically Tagged Cache Lookup

This block holds the lookup and miss path of a 16 KB, 4-way set-associative cache. The set index comes from the virtual address, and the tag check uses the physical address. Each resident line keeps a 6-bit hint, which is a slice of its virtual tag. The hint lets the block pick one way before address translation is done. The block reads that way's data word and offers it speculatively one cycle after the request is accepted. In the same cycle it reads the physical tag of that one way, and only that way. The tag is compared against the translated address, which an outside translator delivers during that cycle. The registered hit or miss result follows one cycle later.

Because a hint is much narrower than a full virtual tag, unrelated lines can carry the same hint. On a miss where the hint matched but the physical tag did not, the line is refilled into the hinted way. This keeps at most one way per set answering any hint. Misses with no hint match fill an empty way if the set has one. Otherwise they use a per-set round-robin victim. Refill data arrives as eight 32-bit beats on a plain fill port. New requests stall from the cycle a miss is resolved until the last beat is written.

Top module: `vipt_hint_cache`

## Requirements
- R1: After reset, req_ready is 1 and early_valid, resp_valid and refill_req are 0. Every entry is invalid, so the first access to any line reports a miss.
- R2: In the cycle after a request is accepted, early_valid is 1. If a valid way in set VA[11:5] has a hint equal to VA[17:12], early_data is word VA[4:2] of that way.
- R3: One cycle after early_valid, resp_valid is 1. resp_hit is 1 exactly when the hint-selected way's stored tag equals xlat_paddr[35:12] as driven during the early cycle. On a hit, resp_data is the word from R2.
- R4: A line whose physical tag matches but which was filled under a different hint is reported as a miss.
- R5: No set ever holds two valid ways with the same hint.
- R6: A miss whose hint matched a valid way refills that same way, whatever the round-robin state.
- R7: A miss with no hint match fills the lowest-numbered invalid way. If no way is invalid, it fills the way named by the set's round-robin pointer. The pointer starts at way 0 and advances by one, modulo 4, only when it is used.
- R8: In the cycle resp_valid reports a miss, refill_req is 1 for exactly one cycle and refill_line is xlat_paddr[35:5] of the missing access. req_ready is 0 from the miss cycle until the final fill beat has been taken.
- R9: A refill takes eight beats on fill_valid, and beat k carries word k of the line. Once the last beat is taken, the line hits. fill_valid is ignored when no refill is in progress.
- R10: req_valid is ignored while req_ready is 0. Requests that hit are accepted on consecutive cycles, with one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual byte address of the request |
| req_ready | output | 1 | Request can be accepted this cycle |
| xlat_paddr | input | 36 | Translated physical address, driven in the cycle after acceptance |
| early_valid | output | 1 | Speculative data strobe |
| early_data | output | 32 | Word from the hint-selected way |
| resp_valid | output | 1 | Final result strobe |
| resp_hit | output | 1 | 1 = hit, 0 = miss |
| resp_data | output | 32 | Word returned on a hit |
| refill_req | output | 1 | One-cycle refill request |
| refill_line | output | 31 | Physical line address to refill |
| fill_valid | input | 1 | Refill beat present |
| fill_data | input | 32 | Refill beat data, word order 0..7 |

## Verification
Speculative data is due one clock edge after acceptance, and the registered hit flag and data one edge after that. A miss raises refill_req in that same result cycle, and the refilled line can hit on the first request after the eighth beat. The bench drives every input at the falling edge and samples one time unit later. It checks each request's early word on the next falling edge, its result on the one after, and its refill handshake beat by beat. The expected values come from a behavioural set model that applies the hint, eviction and round-robin rules on its own.

// File: rtl/vipt_cache_pkg.sv
package vipt_cache_pkg;

  // refill sequencing state
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_FILL = 2'd2
  } fill_state_t;

endpackage

// File: rtl/hint_tag_store.sv
module hint_tag_store #(
  parameter int WAYS      = 4,
  parameter int SETS      = 128,
  parameter int HINT_BITS = 6,
  parameter int PTAG_BITS = 24,
  localparam int IDX_BITS = $clog2(SETS),
  localparam int WAY_BITS = $clog2(WAYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_BITS-1:0]  rd_set,
  input  logic [HINT_BITS-1:0] rd_hint,
  input  logic [WAY_BITS-1:0]  rd_way,
  output logic [WAYS-1:0]      hint_match,
  output logic [WAYS-1:0]      valid_row,
  output logic [PTAG_BITS-1:0] rd_tag,
  output logic [WAY_BITS-1:0]  rr_row,
  input  logic                 inv_en,
  input  logic [WAY_BITS-1:0]  inv_way,
  input  logic                 rr_adv_en,
  input  logic                 commit_en,
  input  logic [IDX_BITS-1:0]  commit_set,
  input  logic [WAY_BITS-1:0]  commit_way,
  input  logic [HINT_BITS-1:0] commit_hint,
  input  logic [PTAG_BITS-1:0] commit_tag
);

  logic [WAYS-1:0]      valid_q [SETS];
  logic [WAYS-1:0]      valid_d [SETS];
  logic [WAY_BITS-1:0]  rr_q    [SETS];
  logic [WAY_BITS-1:0]  rr_d    [SETS];
  logic [HINT_BITS-1:0] hint_q  [SETS][WAYS];
  logic [PTAG_BITS-1:0] tag_q   [SETS][WAYS];

  // lookup side: every hint of the set, a single tag
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      hint_match[w] = valid_q[rd_set][w] && (hint_q[rd_set][w] == rd_hint);
    end
  end
  assign valid_row = valid_q[rd_set];
  assign rr_row    = rr_q[rd_set];
  assign rd_tag    = tag_q[rd_set][rd_way];

  // next state of valid bits and round-robin pointers
  always_comb begin
    valid_d = valid_q;
    rr_d    = rr_q;
    if (inv_en) begin
      valid_d[rd_set][inv_way] = 1'b0;
    end
    if (rr_adv_en) begin
      rr_d[rd_set] = rr_q[rd_set] + 1'b1;
    end
    if (commit_en) begin
      valid_d[commit_set][commit_way] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  // hint and tag arrays: written only when a refill completes
  always_ff @(posedge clk) begin
    if (commit_en) begin
      hint_q[commit_set][commit_way] <= commit_hint;
      tag_q[commit_set][commit_way]  <= commit_tag;
    end
  end

  // ---- assertions ----
  logic                 chk_arm_q;
  logic [IDX_BITS-1:0]  chk_set_q;
  logic [HINT_BITS-1:0] chk_hint_q;
  logic [WAYS-1:0]      post_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_arm_q  <= 1'b0;
      chk_set_q  <= '0;
      chk_hint_q <= '0;
    end else begin
      chk_arm_q  <= commit_en;
      chk_set_q  <= commit_set;
      chk_hint_q <= commit_hint;
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      post_match[w] = valid_q[chk_set_q][w] && (hint_q[chk_set_q][w] == chk_hint_q);
    end
  end

  // R5: a lookup never sees two ways carrying its hint
  p_hint_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hint_match));

  // R5: right after a refill the written hint is held by exactly one way
  p_hint_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_arm_q |-> ($countones(post_match) == 1));

endmodule

// File: rtl/line_data_store.sv
module line_data_store #(
  parameter int WAYS      = 4,
  parameter int SETS      = 128,
  parameter int BEATS     = 8,
  parameter int WORD_BITS = 32,
  localparam int IDX_BITS  = $clog2(SETS),
  localparam int WAY_BITS  = $clog2(WAYS),
  localparam int WOFF_BITS = $clog2(BEATS),
  localparam int DEPTH     = SETS * BEATS
) (
  input  logic                 clk,
  input  logic [IDX_BITS-1:0]  rd_set,
  input  logic [WOFF_BITS-1:0] rd_word,
  input  logic [WAY_BITS-1:0]  rd_way,
  output logic [WORD_BITS-1:0] rd_data,
  input  logic                 wr_en,
  input  logic [IDX_BITS-1:0]  wr_set,
  input  logic [WAY_BITS-1:0]  wr_way,
  input  logic [WOFF_BITS-1:0] wr_word,
  input  logic [WORD_BITS-1:0] wr_data
);

  logic [WORD_BITS-1:0] way_rd [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [WORD_BITS-1:0] mem [DEPTH];
    logic                 we;

    assign we = wr_en && (wr_way == WAY_BITS'(w));

    always_ff @(posedge clk) begin
      if (we) begin
        mem[{wr_set, wr_word}] <= wr_data;
      end
    end

    assign way_rd[w] = mem[{rd_set, rd_word}];
  end

  assign rd_data = way_rd[rd_way];

endmodule

// File: rtl/way_select.sv
module way_select #(
  parameter int WAYS = 4,
  localparam int WAY_BITS = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]     hint_match,
  input  logic [WAYS-1:0]     valid_row,
  input  logic [WAY_BITS-1:0] rr_row,
  output logic                any_match,
  output logic [WAY_BITS-1:0] match_way,
  output logic [WAY_BITS-1:0] victim_way,
  output logic                use_rr
);

  logic                has_free;
  logic [WAY_BITS-1:0] free_way;

  always_comb begin
    any_match = 1'b0;
    match_way = '0;
    has_free  = 1'b0;
    free_way  = '0;
    // scan downward so the lowest index wins
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hint_match[w]) begin
        any_match = 1'b1;
        match_way = WAY_BITS'(w);
      end
      if (!valid_row[w]) begin
        has_free = 1'b1;
        free_way = WAY_BITS'(w);
      end
    end
  end

  always_comb begin
    use_rr = 1'b0;
    if (any_match) begin
      victim_way = match_way;
    end else if (has_free) begin
      victim_way = free_way;
    end else begin
      victim_way = rr_row;
      use_rr     = 1'b1;
    end
  end

endmodule

// File: rtl/vipt_hint_cache.sv
module vipt_hint_cache
  import vipt_cache_pkg::*;
#(
  parameter int VA_BITS    = 32,
  parameter int PA_BITS    = 36,
  parameter int WORD_BITS  = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int HINT_BITS  = 6,
  localparam int BYTE_BITS = $clog2(WORD_BITS / 8),
  localparam int BEATS     = LINE_BYTES / (WORD_BITS / 8),
  localparam int WOFF_BITS = $clog2(BEATS),
  localparam int OFF_BITS  = $clog2(LINE_BYTES),
  localparam int IDX_BITS  = $clog2(SETS),
  localparam int WAY_BITS  = $clog2(WAYS),
  localparam int HINT_LSB  = OFF_BITS + IDX_BITS,
  localparam int PTAG_BITS = PA_BITS - HINT_LSB,
  localparam int LINE_BITS = PA_BITS - OFF_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [VA_BITS-1:0]   req_vaddr,
  output logic                 req_ready,
  input  logic [PA_BITS-1:0]   xlat_paddr,
  output logic                 early_valid,
  output logic [WORD_BITS-1:0] early_data,
  output logic                 resp_valid,
  output logic                 resp_hit,
  output logic [WORD_BITS-1:0] resp_data,
  output logic                 refill_req,
  output logic [LINE_BITS-1:0] refill_line,
  input  logic                 fill_valid,
  input  logic [WORD_BITS-1:0] fill_data
);

  // address bits this block does not decode
  logic unused_va;
  logic unused_pa;
  assign unused_va = ^{req_vaddr[VA_BITS-1:HINT_LSB+HINT_BITS], req_vaddr[BYTE_BITS-1:0]};
  assign unused_pa = ^xlat_paddr[HINT_LSB-1:0];

  // ---------------- lookup stage registers ----------------
  logic                 s1_valid_q, s1_valid_d;
  logic [IDX_BITS-1:0]  s1_set_q,   s1_set_d;
  logic [WOFF_BITS-1:0] s1_word_q,  s1_word_d;
  logic [HINT_BITS-1:0] s1_hint_q,  s1_hint_d;

  // ---------------- refill registers ----------------
  fill_state_t          state_q, state_d;
  logic [WOFF_BITS-1:0] beat_q,  beat_d;
  logic [WAY_BITS-1:0]  fway_q,  fway_d;
  logic [IDX_BITS-1:0]  fset_q,  fset_d;
  logic [HINT_BITS-1:0] fhint_q, fhint_d;
  logic [PTAG_BITS-1:0] ftag_q,  ftag_d;

  // ---------------- result registers ----------------
  logic                 resp_valid_q, resp_hit_q;
  logic [WORD_BITS-1:0] resp_data_q,  resp_data_d;

  // ---------------- lookup datapath ----------------
  logic [WAYS-1:0]      hint_match, valid_row;
  logic [PTAG_BITS-1:0] rd_tag;
  logic [WAY_BITS-1:0]  rr_row, match_way, victim_way;
  logic                 any_match, use_rr;
  logic [PTAG_BITS-1:0] ptag_now;
  logic                 hit_now, miss_now, accept;
  logic                 inv_en, rr_adv_en, commit_en, data_we;

  hint_tag_store #(
    .WAYS(WAYS), .SETS(SETS), .HINT_BITS(HINT_BITS), .PTAG_BITS(PTAG_BITS)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_set(s1_set_q), .rd_hint(s1_hint_q), .rd_way(match_way),
    .hint_match(hint_match), .valid_row(valid_row), .rd_tag(rd_tag), .rr_row(rr_row),
    .inv_en(inv_en), .inv_way(victim_way), .rr_adv_en(rr_adv_en),
    .commit_en(commit_en), .commit_set(fset_q), .commit_way(fway_q),
    .commit_hint(fhint_q), .commit_tag(ftag_q)
  );

  way_select #(.WAYS(WAYS)) u_sel (
    .hint_match(hint_match), .valid_row(valid_row), .rr_row(rr_row),
    .any_match(any_match), .match_way(match_way),
    .victim_way(victim_way), .use_rr(use_rr)
  );

  line_data_store #(
    .WAYS(WAYS), .SETS(SETS), .BEATS(BEATS), .WORD_BITS(WORD_BITS)
  ) u_data (
    .clk(clk),
    .rd_set(s1_set_q), .rd_word(s1_word_q), .rd_way(match_way), .rd_data(early_data),
    .wr_en(data_we), .wr_set(fset_q), .wr_way(fway_q), .wr_word(beat_q), .wr_data(fill_data)
  );

  assign ptag_now  = xlat_paddr[PA_BITS-1 -: PTAG_BITS];
  assign hit_now   = any_match && (rd_tag == ptag_now);
  assign miss_now  = s1_valid_q && !hit_now;
  assign req_ready = (state_q == FS_IDLE) && !miss_now;
  assign accept    = req_valid && req_ready;

  // ---------------- lookup stage next state ----------------
  always_comb begin
    s1_valid_d = accept;
    s1_set_d   = s1_set_q;
    s1_word_d  = s1_word_q;
    s1_hint_d  = s1_hint_q;
    if (accept) begin
      s1_set_d  = req_vaddr[OFF_BITS +: IDX_BITS];
      s1_word_d = req_vaddr[BYTE_BITS +: WOFF_BITS];
      s1_hint_d = req_vaddr[HINT_LSB +: HINT_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_set_q   <= '0;
      s1_word_q  <= '0;
      s1_hint_q  <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_set_q   <= s1_set_d;
      s1_word_q  <= s1_word_d;
      s1_hint_q  <= s1_hint_d;
    end
  end

  // ---------------- refill sequencing ----------------
  always_comb begin
    state_d   = state_q;
    beat_d    = beat_q;
    fway_d    = fway_q;
    fset_d    = fset_q;
    fhint_d   = fhint_q;
    ftag_d    = ftag_q;
    inv_en    = 1'b0;
    rr_adv_en = 1'b0;
    commit_en = 1'b0;
    data_we   = 1'b0;
    unique case (state_q)
      FS_IDLE: begin
        if (miss_now) begin
          state_d   = FS_REQ;
          beat_d    = '0;
          fway_d    = victim_way;
          fset_d    = s1_set_q;
          fhint_d   = s1_hint_q;
          ftag_d    = ptag_now;
          inv_en    = 1'b1;
          rr_adv_en = use_rr;
        end
      end
      FS_REQ: begin
        state_d = FS_FILL;
      end
      FS_FILL: begin
        if (fill_valid) begin
          data_we = 1'b1;
          beat_d  = beat_q + 1'b1;
          if (beat_q == WOFF_BITS'(BEATS - 1)) begin
            commit_en = 1'b1;
            state_d   = FS_IDLE;
          end
        end
      end
      default: begin
        state_d = FS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      beat_q  <= '0;
      fway_q  <= '0;
      fset_q  <= '0;
      fhint_q <= '0;
      ftag_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      fway_q  <= fway_d;
      fset_q  <= fset_d;
      fhint_q <= fhint_d;
      ftag_q  <= ftag_d;
    end
  end

  assign refill_req  = (state_q == FS_REQ);
  assign refill_line = {ftag_q, fset_q};

  // ---------------- result stage ----------------
  always_comb begin
    resp_data_d = resp_data_q;
    if (s1_valid_q) begin
      resp_data_d = early_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      resp_valid_q <= s1_valid_q;
      resp_hit_q   <= s1_valid_q && hit_now;
      resp_data_q  <= resp_data_d;
    end
  end

  assign early_valid = s1_valid_q;
  assign resp_valid  = resp_valid_q;
  assign resp_hit    = resp_hit_q;
  assign resp_data   = resp_data_q;

  // ---------------- assertions ----------------
  // R3: every speculative strobe is followed by a final result
  p_resp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    early_valid |=> resp_valid);

  // R8: a refill request lasts a single cycle
  p_refill_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |=> !refill_req);

  // R8: a missed result is accompanied by the refill request
  p_miss_requests_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> refill_req);

  // R10: no lookup is accepted while a refill is in flight
  p_stall_in_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != FS_IDLE) |-> (!req_ready && !early_valid));

endmodule

// File: tb/vipt_hint_cache_tb_top.sv
module vipt_hint_cache_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_ready;
  logic [35:0] xlat_paddr;
  logic        early_valid;
  logic [31:0] early_data;
  logic        resp_valid;
  logic        resp_hit;
  logic [31:0] resp_data;
  logic        refill_req;
  logic [30:0] refill_line;
  logic        fill_valid;
  logic [31:0] fill_data;

  always #5 clk = ~clk;

  vipt_hint_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .xlat_paddr(xlat_paddr),
    .early_valid(early_valid), .early_data(early_data),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
    .refill_req(refill_req), .refill_line(refill_line),
    .fill_valid(fill_valid), .fill_data(fill_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // behavioural model of the set contents
  bit          m_v    [128][4];
  int          m_h    [128][4];
  logic [30:0] m_line [128][4];
  int          m_rr   [128];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fdat(input logic [30:0] line, input int k);
    logic [2:0] kk;
    kk = k[2:0];
    return {line[20:0], 8'h00, kk} ^ 32'h5A3C_96E1;
  endfunction

  function automatic int m_find(input int s, input int h);
    for (int w = 0; w < 4; w++) begin
      if (m_v[s][w] && m_h[s][w] == h) return w;
    end
    return -1;
  endfunction

  function automatic logic [31:0] mk_va(input int h, input int s, input int wd);
    logic [5:0] hh; logic [6:0] ss; logic [2:0] ww;
    hh = h[5:0]; ss = s[6:0]; ww = wd[2:0];
    return {14'h0, hh, ss, ww, 2'b00};
  endfunction

  function automatic logic [35:0] mk_pa(input logic [23:0] pt, input int s, input int wd);
    logic [6:0] ss; logic [2:0] ww;
    ss = s[6:0]; ww = wd[2:0];
    return {pt, ss, ww, 2'b00};
  endfunction

  // one complete access, refilling on a miss
  task automatic access(input int h, input int s, input int wd, input logic [23:0] pt, input bit poke);
    logic [31:0] va;
    logic [35:0] pa;
    logic [30:0] line;
    int          w, vw;
    bit          exp_hit;
    va   = mk_va(h, s, wd);
    pa   = mk_pa(pt, s, wd);
    line = pa[35:5];
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    #1 chk(req_ready == 1'b1, "R8 ready while idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid  = 1'b0;
    xlat_paddr = pa;
    w       = m_find(s, h);
    exp_hit = (w >= 0) && (m_line[s][w][30:7] == pt);
    #1;
    chk(early_valid == 1'b1, "R2 early strobe", 64'(early_valid), 64'd1);
    if (w >= 0) chk(early_data == fdat(m_line[s][w], wd), "R2 early word", 64'(early_data), 64'(fdat(m_line[s][w], wd)));
    chk(req_ready == exp_hit, "R8 ready drops on miss", 64'(req_ready), 64'(exp_hit));
    @(negedge clk);
    #1;
    chk(resp_valid == 1'b1, "R3 result strobe", 64'(resp_valid), 64'd1);
    chk(resp_hit == exp_hit, "R3 R4 hit flag", 64'(resp_hit), 64'(exp_hit));
    if (exp_hit) begin
      chk(resp_data == fdat(line, wd), "R3 result word", 64'(resp_data), 64'(fdat(line, wd)));
    end else begin
      chk(refill_req == 1'b1, "R8 refill request", 64'(refill_req), 64'd1);
      chk(refill_line == line, "R8 refill line", 64'(refill_line), 64'(line));
      if (w >= 0) begin
        vw = w;  // R6: hinted way is the victim
      end else begin
        vw = -1;
        for (int i = 0; i < 4; i++) if (vw < 0 && !m_v[s][i]) vw = i;
        if (vw < 0) begin  // R7 round-robin
          vw = m_rr[s];
          m_rr[s] = (m_rr[s] + 1) % 4;
        end
      end
      m_v[s][vw] = 1'b0;
      @(negedge clk);
      #1 chk(refill_req == 1'b0, "R8 refill pulse width", 64'(refill_req), 64'd0);
      for (int k = 0; k < 8; k++) begin
        chk(req_ready == 1'b0, "R8 stalled during refill", 64'(req_ready), 64'd0);
        fill_valid = 1'b1;
        fill_data  = fdat(line, k);
        if (poke) begin
          req_valid = 1'b1;
          req_vaddr = va;
        end
        @(negedge clk);
        #1;
      end
      fill_valid = 1'b0;
      req_valid  = 1'b0;
      #1;
      chk(req_ready == 1'b1, "R8 ready after last beat", 64'(req_ready), 64'd1);
      chk(early_valid == 1'b0, "R10 request during refill ignored", 64'(early_valid), 64'd0);
      m_v[s][vw]    = 1'b1;
      m_h[s][vw]    = h;
      m_line[s][vw] = line;
    end
  endtask

  // hits issued on consecutive cycles
  int          bh [8];
  int          bs [8];
  int          bw [8];
  logic [23:0] bp [8];

  task automatic burst(input int n);
    for (int c = 0; c < n + 2; c++) begin
      @(negedge clk);
      if (c < n) begin
        req_valid = 1'b1;
        req_vaddr = mk_va(bh[c], bs[c], bw[c]);
      end else begin
        req_valid = 1'b0;
      end
      if (c >= 1 && c <= n) xlat_paddr = mk_pa(bp[c-1], bs[c-1], bw[c-1]);
      #1;
      if (c < n) chk(req_ready == 1'b1, "R10 back-to-back accept", 64'(req_ready), 64'd1);
      if (c >= 1 && c <= n) begin
        chk(early_valid == 1'b1, "R10 early strobe per cycle", 64'(early_valid), 64'd1);
        chk(early_data == fdat({bp[c-1], bs[c-1][6:0]}, bw[c-1]), "R10 early word",
            64'(early_data), 64'(fdat({bp[c-1], bs[c-1][6:0]}, bw[c-1])));
      end
      if (c >= 2) begin
        chk(resp_valid && resp_hit, "R10 result per cycle", 64'({resp_valid, resp_hit}), 64'd3);
        chk(resp_data == fdat({bp[c-2], bs[c-2][6:0]}, bw[c-2]), "R10 result word",
            64'(resp_data), 64'(fdat({bp[c-2], bs[c-2][6:0]}, bw[c-2])));
      end
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 128; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) begin
        m_v[s][w] = 1'b0; m_h[s][w] = 0; m_line[s][w] = '0;
      end
    end
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; xlat_paddr = '0;
    fill_valid = 1'b0; fill_data = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    chk(early_valid == 1'b0, "R1 reset early", 64'(early_valid), 64'd0);
    chk(resp_valid == 1'b0, "R1 reset result", 64'(resp_valid), 64'd0);
    chk(refill_req == 1'b0, "R1 reset refill", 64'(refill_req), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 cold miss, R9 refill then hits on other words
    access(1, 5, 3, 24'd100, 1'b0);
    access(1, 5, 3, 24'd100, 1'b0);
    access(1, 5, 7, 24'd100, 1'b0);
    access(1, 5, 0, 24'd100, 1'b0);
    // R7 fill the remaining empty ways, R10 requests poked during refill
    access(2, 5, 1, 24'd101, 1'b1);
    access(3, 5, 2, 24'd102, 1'b0);
    access(4, 5, 4, 24'd103, 1'b1);
    // same hint and tag in another set
    access(1, 0, 5, 24'd100, 1'b0);
    // R10 all four ways hit back to back
    bh = '{1, 2, 3, 4, 1, 4, 2, 3}; bs = '{5, 5, 5, 5, 0, 5, 5, 5};
    bw = '{0, 1, 2, 3, 4, 5, 6, 7};
    bp = '{24'd100, 24'd101, 24'd102, 24'd103, 24'd100, 24'd103, 24'd101, 24'd102};
    burst(8);
    // R7 full set: round-robin victims
    access(9, 5, 2, 24'd104, 1'b0);
    access(1, 5, 2, 24'd100, 1'b0);
    access(9, 5, 6, 24'd104, 1'b0);
    // R6 same hint, different physical line: hinted way is replaced
    access(3, 5, 1, 24'd200, 1'b0);
    access(4, 5, 1, 24'd103, 1'b0);
    access(1, 5, 1, 24'd100, 1'b0);
    access(3, 5, 5, 24'd200, 1'b0);
    access(3, 5, 5, 24'd102, 1'b0);
    // R4 resident physical line reached under another hint misses
    access(12, 5, 0, 24'd103, 1'b0);
    access(12, 5, 3, 24'd103, 1'b0);
    // R9 stray fill beats while idle leave contents untouched
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      fill_valid = 1'b1;
      fill_data  = 32'hDEAD_0000 + i;
    end
    @(negedge clk);
    fill_valid = 1'b0;
    access(1, 0, 5, 24'd100, 1'b0);
    access(12, 5, 6, 24'd103, 1'b0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule